// File: doc/BRIEF.md
# Frame-Aligned Dual-Lane I/Q Sample Deserializer

This block turns two serial data lanes and a frame-marker lane from a radar ADC serial link into complex samples. External DDR input registers split each lane into a rising-edge bit and a falling-edge bit, so every system clock brings two bits per lane and two marker bits. The rising-edge bit is always the earlier of the two. The marker is a 50%-duty square wave whose period is one sample width. Its low-to-high edge marks the first bit of every sample.

The deserializer aligns to that edge and shifts in 12, 14 or 16 bits per lane, most significant bit first. Lane 0 carries the in-phase part and lane 1 carries the quadrature part. It then presents one right-justified I/Q pair with a one-cycle valid strobe. Channels deliver their samples in turn: 256 samples of channel 0, then channels 1, 2 and 3. Each pair is therefore tagged with a sample index and a channel index, and the first sample of channel 0 carries a start-of-frame pulse. The block checks the marker's timing continuously and keeps a sticky error flag.

Top module: `radar_lane_deser`

## Requirements
- R1: After reset, `smp_valid`, `frame_start` and `frame_err` are low, and no sample is produced until a marker rising edge is seen.
- R2: `width_sel` picks the sample width: 2'b00 selects 12 bits, 2'b01 selects 14 bits, and 2'b10 or 2'b11 selects 16 bits. Samples are shifted in MSB first and presented right-justified in 16 bits, with zeros above the selected width.
- R3: A marker bit of 1 whose preceding marker bit was 0 starts a word with that bit. Bits seen before the first such edge are ignored. The edge may fall in the rising-edge slot or in the falling-edge slot of a cycle.
- R4: `smp_i` comes from lane 0 and `smp_q` comes from lane 1.
- R5: `smp_valid` is high for exactly one cycle per word. It is high in the cycle after the clock edge that captured the word's last bit.
- R6: `smp_index` counts 0 to 255 and then wraps to 0. On each wrap `smp_chan` advances, going 0, 1, 2, 3 and back to 0.
- R7: `frame_start` is high together with `smp_valid` exactly when the sample has index 0 on channel 0.
- R8: A marker level that disagrees with the expected pattern sets `frame_err`, which stays set until reset. The pattern is a rising edge at the word boundary, then high for the first half of the width and low for the second half. The damaged word is dropped, and capture restarts at the next rising edge (immediately if the faulty bit is itself a rising edge). The sample and channel counters keep running.
- R9: A change of `width_sel` discards the bits of that cycle, drops any partial word, clears alignment and resets the sample and channel counters to 0. It does not clear `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 2 | Sample width select |
| lane0_rise | input | 1 | Lane 0 bit captured on the rising edge (earlier bit) |
| lane0_fall | input | 1 | Lane 0 bit captured on the falling edge (later bit) |
| lane1_rise | input | 1 | Lane 1 bit captured on the rising edge |
| lane1_fall | input | 1 | Lane 1 bit captured on the falling edge |
| mark_rise | input | 1 | Frame-marker bit captured on the rising edge |
| mark_fall | input | 1 | Frame-marker bit captured on the falling edge |
| smp_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| smp_i | output | 16 | In-phase sample, right-justified |
| smp_q | output | 16 | Quadrature sample, right-justified |
| smp_chan | output | 2 | Receive-channel index of the pair |
| smp_index | output | 8 | Sample index within the channel |
| frame_start | output | 1 | High with the pair for sample 0 of channel 0 |
| frame_err | output | 1 | Sticky marker-timing error |

## Verification
The hardest situations to reach from the ports are the ones where word boundaries stop falling on cycle boundaries. That happens when a rising marker edge lands in the falling-edge slot, or when an error makes capture restart at an odd bit position. The bench drives a bit-level queue and pops two bits per cycle. A single extra idle bit, or a deliberately truncated word, therefore moves every later boundary into the other slot. Each error case is followed by well-formed words, so the bench can confirm that capture restarts at the new edge.

// File: rtl/radar_lane_deser.sv
module radar_lane_deser #(
  parameter int SAMPLES  = 256,
  parameter int CHANNELS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  width_sel,
  input  logic        lane0_rise,
  input  logic        lane0_fall,
  input  logic        lane1_rise,
  input  logic        lane1_fall,
  input  logic        mark_rise,
  input  logic        mark_fall,
  output logic        smp_valid,
  output logic [15:0] smp_i,
  output logic [15:0] smp_q,
  output logic [$clog2(CHANNELS)-1:0] smp_chan,
  output logic [$clog2(SAMPLES)-1:0]  smp_index,
  output logic        frame_start,
  output logic        frame_err
);
  localparam int DW = 16;
  localparam int IW = $clog2(SAMPLES);
  localparam int CW = $clog2(CHANNELS);

  typedef struct packed {
    logic          prev;
    logic          al;
    logic [4:0]    cnt;
    logic [DW-1:0] si;
    logic [DW-1:0] sq;
    logic          err;
    logic          emit;
  } st_t;

  st_t cur, s0, s1, s2, nxt;
  logic [1:0]    wsel_q;
  logic [IW-1:0] idx_c;
  logic [CW-1:0] ch_c;
  logic [4:0]    wlen;

  assign wlen = (width_sel == 2'b00) ? 5'd12 : (width_sel == 2'b01) ? 5'd14 : 5'd16;

  function automatic st_t step(input st_t s, input logic fm, input logic bi,
                               input logic bq, input logic [4:0] w);
    st_t  n;
    logic rise, ok;
    n      = s;
    n.emit = 1'b0;
    n.prev = fm;
    rise   = fm & ~s.prev;
    ok     = (s.cnt == 5'd0) ? rise : (fm == (s.cnt < (w >> 1)));
    if (s.al && !ok) begin
      n.err = 1'b1;
      n.al  = 1'b0;
    end
    if (rise) begin
      n.al  = 1'b1;
      n.cnt = 5'd1;
      n.si  = {{(DW-1){1'b0}}, bi};
      n.sq  = {{(DW-1){1'b0}}, bq};
    end else if (n.al) begin
      n.si  = {s.si[DW-2:0], bi};
      n.sq  = {s.sq[DW-2:0], bq};
      n.cnt = s.cnt + 5'd1;
    end
    if (n.al && n.cnt == w) begin
      n.emit = 1'b1;
      n.cnt  = 5'd0;
    end
    return n;
  endfunction

  always_comb begin
    s0       = cur;
    s0.emit  = 1'b0;
    s1       = step(s0, mark_rise, lane0_rise, lane1_rise, wlen);
    s2       = step(s1, mark_fall, lane0_fall, lane1_fall, wlen);
    nxt      = s2;
    nxt.emit = s1.emit | s2.emit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur         <= '0;
      wsel_q      <= width_sel;
      idx_c       <= '0;
      ch_c        <= '0;
      smp_i       <= '0;
      smp_q       <= '0;
      smp_index   <= '0;
      smp_chan    <= '0;
      frame_start <= 1'b0;
    end else begin
      wsel_q <= width_sel;
      if (width_sel != wsel_q) begin
        cur.al      <= 1'b0;
        cur.cnt     <= 5'd0;
        cur.prev    <= mark_fall;
        cur.emit    <= 1'b0;
        idx_c       <= '0;
        ch_c        <= '0;
        frame_start <= 1'b0;
      end else begin
        cur         <= nxt;
        frame_start <= nxt.emit && idx_c == '0 && ch_c == '0;
        if (nxt.emit) begin
          smp_i     <= s1.emit ? s1.si : s2.si;
          smp_q     <= s1.emit ? s1.sq : s2.sq;
          smp_index <= idx_c;
          smp_chan  <= ch_c;
          if (idx_c == IW'(SAMPLES - 1)) begin
            idx_c <= '0;
            ch_c  <= (ch_c == CW'(CHANNELS - 1)) ? '0 : ch_c + 1'b1;
          end else begin
            idx_c <= idx_c + 1'b1;
          end
        end
      end
    end
  end

  assign smp_valid = cur.emit;
  assign frame_err = cur.err;
endmodule

// File: rtl/radar_lane_deser_chk.sv
module radar_lane_deser_chk #(
  parameter int IW = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    width_sel,
  input logic          smp_valid,
  input logic [15:0]   smp_i,
  input logic [15:0]   smp_q,
  input logic [CW-1:0] smp_chan,
  input logic [IW-1:0] smp_index,
  input logic          frame_start,
  input logic          frame_err
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R8
  AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> smp_valid && smp_index == '0 && smp_chan == '0); // R7
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && $past(width_sel) == 2'b00 |-> smp_i[15:12] == 4'd0 && smp_q[15:12] == 4'd0); // R2
endmodule

bind radar_lane_deser radar_lane_deser_chk #(.IW($clog2(SAMPLES)), .CW($clog2(CHANNELS))) u_chk (.*);

// File: tb/radar_lane_deser_bench.sv
module radar_lane_deser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic l0r = 1'b0, l0f = 1'b0, l1r = 1'b0, l1f = 1'b0, mr = 1'b0, mf = 1'b0;
  logic smp_valid, frame_start, frame_err;
  logic [15:0] smp_i, smp_q;
  logic [1:0] smp_chan;
  logic [7:0] smp_index;

  always #10 clk = ~clk;

  radar_lane_deser u_radar_lane_deser (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .lane0_rise(l0r), .lane0_fall(l0f), .lane1_rise(l1r), .lane1_fall(l1f),
    .mark_rise(mr), .mark_fall(mf),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .smp_chan(smp_chan),
    .smp_index(smp_index), .frame_start(frame_start), .frame_err(frame_err));

  typedef struct { bit m; bit a; bit b; bit [1:0] w; } bit_t;
  typedef struct { int i; int q; int ch; int idx; bit sof; bit chk; bit err; string req; } item_t;
  bit_t  bitq[$];
  item_t expq[$];
  int checks = 0, failures = 0;
  int eidx = 0, ech = 0;
  bit [1:0] tw = 2'b00, last_w = 2'b00;

  function automatic int wlen(bit [1:0] c);
    return (c == 2'b00) ? 12 : (c == 2'b01) ? 14 : 16;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_bit(bit m, bit a, bit b);
    bit_t e;
    e.m = m; e.a = a; e.b = b; e.w = tw;
    if (tw != last_w) begin eidx = 0; ech = 0; last_w = tw; end
    bitq.push_back(e);
  endtask

  task automatic push_idle(int n, bit d);
    for (int k = 0; k < n; k++) push_bit(1'b0, d, d);
  endtask

  task automatic push_word(int iv, int qv, bit chk_e, bit err_e, string req);
    int w = wlen(tw);
    item_t it;
    iv = iv & ((1 << w) - 1);
    qv = qv & ((1 << w) - 1);
    for (int p = 0; p < w; p++) push_bit(p < w / 2, iv[w-1-p], qv[w-1-p]);
    it.i = iv; it.q = qv; it.ch = ech; it.idx = eidx; it.sof = (eidx == 0 && ech == 0);
    it.chk = chk_e; it.err = err_e; it.req = req;
    expq.push_back(it);
    if (eidx == 255) begin eidx = 0; ech = (ech + 1) % 4; end else eidx++;
  endtask

  always @(negedge clk) begin
    bit_t e0, e1;
    if (bitq.size() > 0) begin
      e0 = bitq.pop_front();
      width_sel = e0.w;
      mr = e0.m; l0r = e0.a; l1r = e0.b;
      if (bitq.size() > 0) begin
        e1 = bitq.pop_front();
        mf = e1.m; l0f = e1.a; l1f = e1.b;
      end else begin
        mf = 1'b0; l0f = 1'b0; l1f = 1'b0;
      end
    end else begin
      mr = 1'b0; mf = 1'b0; l0r = 1'b0; l0f = 1'b0; l1r = 1'b0; l1f = 1'b0;
    end
  end

  always @(negedge clk) begin
    item_t it;
    if (rst_n && smp_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5", "unexpected valid i", int'(smp_i), 0);
      end else begin
        it = expq.pop_front();
        chk(smp_i == it.i[15:0], it.req, "R4 smp_i", int'(smp_i), it.i);
        chk(smp_q == it.q[15:0], it.req, "R4 smp_q", int'(smp_q), it.q);
        chk(smp_index == it.idx[7:0], it.req, "R6 smp_index", int'(smp_index), it.idx);
        chk(smp_chan == it.ch[1:0], it.req, "R6 smp_chan", int'(smp_chan), it.ch);
        chk(frame_start == it.sof, it.req, "R7 frame_start", int'(frame_start), int'(it.sof));
        if (it.chk) chk(frame_err == it.err, it.req, "R8 frame_err", int'(frame_err), int'(it.err));
      end
    end
  end

  task automatic drain();
    while (bitq.size() != 0 || expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    eidx = 0; ech = 0;
    @(negedge clk);
    chk(smp_valid == 1'b0, "R1", "valid after reset", int'(smp_valid), 0);
    chk(frame_err == 1'b0, "R1", "err after reset", int'(frame_err), 0);
    chk(frame_start == 1'b0, "R1", "sof after reset", int'(frame_start), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 R3 R4 width 12, garbage data before the first edge
    tw = 2'b00;
    push_idle(2, 1'b1);
    push_word('hFFF, 'h000, 1, 0, "R2");
    push_word('h800, 'h001, 1, 0, "R4");
    push_word('h5A3, 'hA5C, 1, 0, "R3");
    drain();
    do_reset();
    // R2 width 14
    tw = 2'b01;
    push_idle(2, 1'b0);
    push_word('h3FFF, 'h2001, 1, 0, "R2");
    for (int k = 0; k < 3; k++) push_word(int'($urandom), int'($urandom), 1, 0, "R2");
    drain();
    do_reset();
    // R2 width 16 with both codes
    tw = 2'b10;
    push_idle(2, 1'b0);
    push_word('hFFFF, 'h8001, 1, 0, "R2");
    push_word(int'($urandom), int'($urandom), 1, 0, "R2");
    tw = 2'b11;
    push_idle(2, 1'b0);
    push_word('h1234, 'hFEDC, 1, 0, "R2");
    push_word(int'($urandom), int'($urandom), 1, 0, "R2");
    drain();
    do_reset();
    // R3 edge in the falling slot
    tw = 2'b00;
    push_idle(2, 1'b0);
    push_idle(1, 1'b1);
    push_word('hABC, 'h123, 1, 0, "R3");
    push_word('h00F, 'hF00, 1, 0, "R3");
    push_word('h777, 'h888, 0, 0, "R3");
    drain();
    do_reset();
    // R6 R7 wrap through all channels
    push_idle(2, 1'b0);
    for (int k = 0; k < 1026; k++) push_word(k, ~k, 1, 0, "R6");
    drain();
    do_reset();
    // R8 early rising edge, realign at once
    push_idle(2, 1'b0);
    push_word('h111, 'h222, 1, 0, "R8");
    for (int k = 0; k < 6; k++) push_bit(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) push_bit(1'b0, 1'b0, 1'b1);
    eidx = eidx;
    push_word('h333, 'h444, 1, 1, "R8");
    push_word('h555, 'h666, 1, 1, "R8");
    drain();
    chk(frame_err == 1'b1, "R8", "sticky err", int'(frame_err), 1);
    do_reset();
    // R8 high run too long
    push_idle(2, 1'b0);
    push_word('h9AB, 'hCDE, 1, 0, "R8");
    for (int p = 0; p < 12; p++) push_bit(p < 7, 1'b1, 1'b1);
    push_word('h0F0, 'h0FF, 1, 1, "R8");
    drain();
    do_reset();
    // R9 width change mid-word
    push_idle(2, 1'b0);
    push_word('h101, 'h202, 1, 0, "R9");
    push_word('h303, 'h404, 1, 0, "R9");
    for (int p = 0; p < 6; p++) push_bit(1'b1, 1'b1, 1'b1);
    tw = 2'b10;
    push_idle(2, 1'b0);
    push_word('hBEEF, 'hCAFE, 1, 0, "R9");
    push_word('h0102, 'h0304, 1, 0, "R9");
    drain();
    chk(expq.size() == 0, "R9", "pending items", expq.size(), 0);
    finish_run();
  end
endmodule